// File: doc/BRIEF.md
# GPIO Expander Port with Change Interrupt

This block is the register core of a 16-pin general-purpose I/O expander. It is meant to sit behind a serial bus target, such as an I2C or SMBus target, which turns bus transactions into single-byte register accesses. The pins are split into two 8-bit banks. Each bank has four registers: an input snapshot, an output value, a read polarity inversion and a direction. The host reaches them through a small strobe bus that carries a register index, a write strobe, a read strobe and a data byte.

Pin inputs go through a two-flop synchronizer. The synchronized value is compared with the snapshot held for each pin, and an active-low interrupt is raised when a pin configured as an input no longer matches its snapshot. A read of a bank's input register returns the synchronized pins XOR the polarity bits. The same read reloads that bank's snapshot, which clears the interrupt for that bank. Output enables and output values come straight from flops, so they cannot glitch. An asynchronous active-low reset returns every register to its default. After reset the block takes the current pin levels as the first snapshot, so pins at a fixed level do not raise the interrupt.

Top module: `gpio_port16`

## Requirements
- R1: During reset and after it, pin_oe is all zeros, pin_out is all ones and int_n is high. Reads return 0xFF for the output and direction registers and 0x00 for the polarity registers.
- R2: The register index is {kind, bank}, where bank is bit 0 and kind is bits 2:1. Kind 0 is input, 1 is output, 2 is polarity and 3 is direction. A direction bit of 1 makes its pin an input (pin_oe bit 0). A 0 makes it an output (pin_oe bit 1). pin_oe takes the new value at the clock edge that samples the write.
- R3: pin_out takes the value written to the output register at the clock edge that samples the write, whatever the direction setting.
- R4: A read of input index 0 or 1 returns that bank's synchronized pin levels XOR its polarity bits. rdata holds the value from the edge that samples rd_en.
- R5: Writes to input indices 0 and 1 have no effect. Outputs, interrupt and later reads are unchanged.
- R6: When an input-configured pin changes, int_n goes low at the third clock edge after the change.
- R7: Pins configured as outputs never cause the interrupt.
- R8: A read of a bank's input register reloads that bank's snapshot. int_n returns high at the edge after the read edge, provided the other bank has no pending change. A read of the other bank leaves the interrupt low.
- R9: When a changed pin returns to its snapshot level, int_n returns high at the third clock edge after the return.
- R10: Asserting rst_n low in the middle of operation restores every register to its default at once, without waiting for a clock edge.
- R11: Output, polarity and direction registers read back the value last written to them.
- R12: Pins held at any fixed level through reset and release do not assert int_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Register index {kind, bank} |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output level |
| int_n | output | 1 | Active-low change interrupt |

## Verification
Register writes show up on pin_oe and pin_out at the edge that samples the strobe. Read data shows up on rdata at the edge that samples rd_en. A pin change reaches int_n three edges later: two for the synchronizer and one for the interrupt flop. A snapshot reload clears int_n one edge after the read. The bench drives every input just after a falling edge and samples just after the next falling edges. Each interrupt test checks int_n after every intermediate edge, so a result that arrives one cycle early or one cycle late is caught.

// File: rtl/gpio_port16.sv
module gpio_port16 #(
  parameter int BANK_W = 8,
  parameter int NBANK = 2,
  localparam int NPIN = BANK_W * NBANK,
  localparam int BSEL_W = $clog2(NBANK),
  localparam int IDX_W = BSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out,
  output logic              int_n
);

  localparam logic [1:0] SEL_IN  = 2'd0;
  localparam logic [1:0] SEL_OUT = 2'd1;
  localparam logic [1:0] SEL_POL = 2'd2;
  localparam logic [1:0] SEL_DIR = 2'd3;

  logic [1:0]        sel;
  logic [BSEL_W-1:0] bsel;
  assign sel  = reg_idx[IDX_W-1 -: 2];
  assign bsel = reg_idx[BSEL_W-1:0];

  logic [NPIN-1:0]   sync_a, sync_b;
  logic [NPIN-1:0]   out_q, dir_q;
  logic [NBANK-1:0]  chg;
  logic [BANK_W-1:0] view [NBANK];
  logic [1:0]        warm;
  logic              ready;
  logic              int_q;
  logic [BANK_W-1:0] rdata_q;

  assign ready = (warm == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (!ready) warm <= warm + 2'd1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    logic              hit;
    logic [BANK_W-1:0] o_r, p_r, d_r, s_r, live;

    assign hit  = (bsel == BSEL_W'(b));
    assign live = sync_b[LO +: BANK_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        o_r <= '1;
        p_r <= '0;
        d_r <= '1;
        s_r <= '0;
      end else begin
        if (wr_en && hit && sel == SEL_OUT) o_r <= wdata;
        if (wr_en && hit && sel == SEL_POL) p_r <= wdata;
        if (wr_en && hit && sel == SEL_DIR) d_r <= wdata;
        if (!ready || (rd_en && hit && sel == SEL_IN)) s_r <= live;
      end
    end

    always_comb begin
      case (sel)
        SEL_IN:  view[b] = live ^ p_r;
        SEL_OUT: view[b] = o_r;
        SEL_POL: view[b] = p_r;
        default: view[b] = d_r;
      endcase
    end

    assign chg[b] = |((live ^ s_r) & d_r);
    assign out_q[LO +: BANK_W] = o_r;
    assign dir_q[LO +: BANK_W] = d_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b1;
    else int_q <= !(ready && (|chg));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= view[bsel];
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign int_n   = int_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/gpio_port16_chk.sv
module gpio_port16_chk #(
  parameter int BANK_W = 8,
  parameter int NBANK = 2,
  localparam int NPIN = BANK_W * NBANK,
  localparam int IDX_W = $clog2(NBANK) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  reg_idx,
  input logic              wr_en,
  input logic [BANK_W-1:0] wdata,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out,
  input logic              int_n
);
  logic [2:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= 3'd0;
    else if (since != 3'd7) since <= since + 3'd1;
  end

  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 3'd0) |-> (pin_oe == '0 && pin_out == '1 && int_n));

  // R12
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since < 3'd4) |-> int_n);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_W'(3 * NBANK)) |=> (pin_oe[BANK_W-1:0] == ~$past(wdata)));

  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_W'(NBANK)) |=> (pin_out[BANK_W-1:0] == $past(wdata)));

  // R5
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx < IDX_W'(NBANK)) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind gpio_port16 gpio_port16_chk #(.BANK_W(BANK_W), .NBANK(NBANK)) u_chk (.*);

// File: tb/tb_gpio_port16.sv
module tb_gpio_port16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out;
  logic        int_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_port16 dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .int_n(int_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    reg_idx = idx; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset(input logic [15:0] pins);
    pin_in = pins;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_defaults();
    logic [7:0] d;
    do_reset(16'h0000);
    chk("R1 pin_oe", 32'(pin_oe), 32'h0000);
    chk("R1 pin_out", 32'(pin_out), 32'hFFFF);
    chk("R1 int_n", 32'(int_n), 32'h1);
    rd(3'd2, d); chk("R1 out0", 32'(d), 32'hFF);
    rd(3'd3, d); chk("R1 out1", 32'(d), 32'hFF);
    rd(3'd4, d); chk("R1 pol0", 32'(d), 32'h00);
    rd(3'd5, d); chk("R1 pol1", 32'(d), 32'h00);
    rd(3'd6, d); chk("R1 dir0", 32'(d), 32'hFF);
    rd(3'd7, d); chk("R1 dir1", 32'(d), 32'hFF);
  endtask

  task automatic t_static_pins();
    logic [7:0] d;
    do_reset(16'hA5C3);
    repeat (4) @(negedge clk);
    chk("R12 int_n quiet", 32'(int_n), 32'h1);
    rd(3'd0, d); chk("R4 in0", 32'(d), 32'hC3);
    rd(3'd1, d); chk("R4 in1", 32'(d), 32'hA5);
  endtask

  task automatic t_dir_out();
    logic [7:0] d;
    do_reset(16'h0000);
    wr(3'd6, 8'h0F);
    chk("R2 pin_oe bank0", 32'(pin_oe), 32'h00F0);
    wr(3'd7, 8'h80);
    chk("R2 pin_oe bank1", 32'(pin_oe), 32'h7FF0);
    wr(3'd2, 8'h5A);
    chk("R3 pin_out bank0", 32'(pin_out), 32'hFF5A);
    wr(3'd3, 8'h3C);
    chk("R3 pin_out bank1", 32'(pin_out), 32'h3C5A);
    wr(3'd4, 8'h96);
    rd(3'd2, d); chk("R11 out0", 32'(d), 32'h5A);
    rd(3'd3, d); chk("R11 out1", 32'(d), 32'h3C);
    rd(3'd4, d); chk("R11 pol0", 32'(d), 32'h96);
    rd(3'd6, d); chk("R11 dir0", 32'(d), 32'h0F);
    rd(3'd7, d); chk("R11 dir1", 32'(d), 32'h80);
  endtask

  task automatic t_polarity();
    logic [7:0] d;
    do_reset(16'h0F33);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'h0F);
    rd(3'd0, d); chk("R4 in0 inverted", 32'(d), 32'hCC);
    rd(3'd1, d); chk("R4 in1 half inverted", 32'(d), 32'h00);
    chk("R4 int_n unaffected by polarity", 32'(int_n), 32'h1);
  endtask

  task automatic t_input_write_ignored();
    logic [7:0] d;
    do_reset(16'h1234);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h00);
    chk("R5 pin_out", 32'(pin_out), 32'hFFFF);
    chk("R5 pin_oe", 32'(pin_oe), 32'h0000);
    @(negedge clk);
    chk("R5 int_n", 32'(int_n), 32'h1);
    rd(3'd0, d); chk("R5 in0", 32'(d), 32'h34);
    rd(3'd1, d); chk("R5 in1", 32'(d), 32'h12);
  endtask

  task automatic t_int_raise_clear();
    logic [7:0] d;
    do_reset(16'h0000);
    pin_in[9] = 1'b1;
    @(negedge clk); chk("R6 int_n edge1", 32'(int_n), 32'h1);
    @(negedge clk); chk("R6 int_n edge2", 32'(int_n), 32'h1);
    @(negedge clk); chk("R6 int_n edge3", 32'(int_n), 32'h0);
    rd(3'd0, d);
    @(negedge clk); chk("R8 other bank read keeps int", 32'(int_n), 32'h0);
    rd(3'd1, d);
    chk("R4 in1 value", 32'(d), 32'h02);
    chk("R8 int_n at read edge", 32'(int_n), 32'h0);
    @(negedge clk); chk("R8 int_n cleared", 32'(int_n), 32'h1);
  endtask

  task automatic t_int_return();
    do_reset(16'h0000);
    pin_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 int_n low", 32'(int_n), 32'h0);
    pin_in[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 int_n still low", 32'(int_n), 32'h0);
    @(negedge clk);
    chk("R9 int_n released", 32'(int_n), 32'h1);
  endtask

  task automatic t_int_masked();
    do_reset(16'h0000);
    wr(3'd6, 8'h00);
    pin_in[5] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 output pin no int", 32'(int_n), 32'h1);
    pin_in[12] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 input pin still raises", 32'(int_n), 32'h0);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    do_reset(16'h0000);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'hFF);
    pin_in[8] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 int low before", 32'(int_n), 32'h0);
    rst_n = 1'b0;
    #1;
    chk("R10 pin_oe async", 32'(pin_oe), 32'h0000);
    chk("R10 pin_out async", 32'(pin_out), 32'hFFFF);
    chk("R10 int_n async", 32'(int_n), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 int_n after", 32'(int_n), 32'h1);
    rd(3'd5, d); chk("R10 pol1 cleared", 32'(d), 32'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_defaults();
    t_static_pins();
    t_dir_out();
    t_polarity();
    t_input_write_ignored();
    t_int_raise_clear();
    t_int_return();
    t_int_masked();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule